// File: doc/BRIEF.md
# Snoop Address Retry Driver

This block is the snooping side of a shared address-retry line on a split-transaction processor bus. It follows the transfer-start and address-acknowledge strobes of each address tenure and takes a snoop result from the cache lookup. If that result asks for a retry, the block pulls the shared line asserted at a fixed bus cycle after the transfer start. It holds the line there until a fixed point after the acknowledge. It then hands the line back with a three-step release: a half-bus-cycle gap at high impedance, one full bus cycle driven negated, and high impedance again.

The block runs on a fast clock at twice the bus rate. A `bus_tick` enable marks the fast cycles that end on a bus clock edge. All bus inputs are sampled only at those edges. The half-cycle gap in the release comes from this two-phase view. If the retried snoop also needs a copy-back of modified data, the block raises bus request at a fixed time after the acknowledge. It holds that request until a grant is sampled, then pulses a copy-back start for the data path.

Bus edges are numbered from the edge that samples transfer start (edge 0). Edge `a` is the edge that samples the acknowledge. "First half" means the fast cycle just after a bus edge; "second half" means the fast cycle after that.

Top module: `snoop_retry_drv`

## Requirements
- R1: A snoop result with `snp_valid`=1 and `snp_retry`=1, sampled at bus edge 1 or 2 of an open tenure, makes the block drive the line from bus edge 3 onward, in both halves of each bus cycle, with `retry_oe`=1 and `retry_val`=1 (value 1 means retry asserted).
- R2: A tenure with no retry request inside that window leaves `retry_oe`=0 throughout. This includes a retry result that arrives late, at bus edge 3 or later, which is ignored.
- R3: Once asserted, the line stays driven with `retry_val`=1 up to, but not including, bus edge a+2.
- R4: The release sequence runs as follows. In the bus cycle after edge a+2, the first half has `retry_oe`=0 and the second half has `retry_oe`=1 with `retry_val`=0. In the bus cycle after edge a+3, the first half has `retry_oe`=1 with `retry_val`=0 and the second half has `retry_oe`=0. The line is never driven negated at any other time.
- R5: When the retried snoop also carried `snp_wb`=1, `bus_req` rises at bus edge a+2.
- R6: `bus_req` stays high until a bus edge samples `bus_grant`=1. It is low after that edge.
- R7: The bus edge that samples the grant while `bus_req` is high makes `cb_start` high for exactly the first half of the following bus cycle.
- R8: A new transfer start may come at edge a+1 or later, even while the previous release sequence is running. The release then finishes unchanged, and the new tenure is timed from its own transfer start.
- R9: During and right after reset, `retry_oe`, `bus_req` and `cb_start` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_tick | input | 1 | High in the fast cycle that ends on a bus clock edge |
| ts_in | input | 1 | Transfer start strobe |
| aack_in | input | 1 | Address acknowledge strobe |
| snp_valid | input | 1 | Snoop lookup result is present |
| snp_retry | input | 1 | Snoop result demands a retry |
| snp_wb | input | 1 | Retried line must be copied back |
| bus_grant | input | 1 | Address bus granted to this snooper |
| retry_oe | output | 1 | Output enable for the shared retry line |
| retry_val | output | 1 | Value on the retry line when enabled (1 = asserted) |
| bus_req | output | 1 | Bus request for the copy-back |
| cb_start | output | 1 | One-cycle start pulse for the copy-back data path |

## Verification
The assertions rely on a few properties of the inputs:
- `bus_tick` is never high in two consecutive fast cycles.
- Acknowledge comes no earlier than bus edge 2 of its tenure.
- The next transfer start waits until at least one bus edge after the acknowledge.

Under these assumptions the retry drive can never overlap its own release, and a negated drive can only come from the release pipeline. The bench keeps within these limits because every stimulus step is one fixed bus cycle, with the enable high only in its first fast cycle. Each scenario also places its acknowledge and follow-on transfer start at or beyond the legal minimum spacing.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

  // Snoop sampling window, counted in bus edges after the transfer start.
  function automatic logic in_window(int unsigned pos, int unsigned last);
    return (pos >= 1) && (pos <= last);
  endfunction

  // Shared-line output enable, built from the drive state and the release phases.
  function automatic logic line_oe(logic drive, logic rel_a, logic rel_b, logic first_half);
    return drive | (rel_a & ~first_half) | (rel_b & first_half);
  endfunction

endpackage

// File: rtl/sar_phase.sv
`timescale 1ns/1ps
module sar_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_tick,
  output logic first_half
);
  always_ff @(posedge clk) begin
    if (!rst_n) first_half <= 1'b0;
    else        first_half <= bus_tick;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tick |=> !bus_tick); // R4
endmodule

// File: rtl/sar_tenure.sv
`timescale 1ns/1ps
module sar_tenure #(
  parameter int T_ASSERT     = 3,
  parameter int T_SNOOP_LAST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_tick,
  input  logic ts_in,
  input  logic aack_in,
  input  logic snp_valid,
  input  logic snp_retry,
  input  logic snp_wb,
  output logic start_drive,
  output logic rel_go,
  output logic rel_wb
);
  localparam int CW = $clog2(T_ASSERT + 2);
  localparam logic [CW-1:0] C_SAT    = CW'(T_ASSERT + 1);
  localparam logic [CW-1:0] C_ASSERT = CW'(T_ASSERT);
  localparam logic [CW-1:0] C_ONE    = CW'(1);

  logic [CW-1:0] edge_cnt;
  logic open_q, retry_q, wb_q;
  logic in_win, snoop_hit, aack_evt, dec_retry, dec_wb;

  assign in_win    = sar_pkg::in_window(32'(edge_cnt), T_SNOOP_LAST);
  assign snoop_hit = bus_tick & open_q & in_win & snp_valid & snp_retry;
  assign aack_evt  = bus_tick & aack_in & open_q;
  assign dec_retry = retry_q | snoop_hit;
  assign dec_wb    = wb_q | (snoop_hit & snp_wb);

  assign start_drive = bus_tick & (edge_cnt == C_ASSERT) & retry_q;
  assign rel_go      = aack_evt & dec_retry;
  assign rel_wb      = aack_evt & dec_wb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_cnt <= C_SAT;
      open_q   <= 1'b0;
      retry_q  <= 1'b0;
      wb_q     <= 1'b0;
    end else if (bus_tick) begin
      if (ts_in) begin
        edge_cnt <= C_ONE;
        open_q   <= 1'b1;
        retry_q  <= 1'b0;
        wb_q     <= 1'b0;
      end else begin
        if (edge_cnt != C_SAT) edge_cnt <= edge_cnt + C_ONE;
        if (aack_evt)          open_q   <= 1'b0;
        if (snoop_hit)         retry_q  <= 1'b1;
        if (snoop_hit & snp_wb) wb_q    <= 1'b1;
      end
    end
  end

  AST_LATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tick && !ts_in && !in_win) |=> $stable(retry_q)); // R2
  AST_DRIVE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    start_drive |=> !start_drive); // R1
endmodule

// File: rtl/sar_release.sv
`timescale 1ns/1ps
module sar_release #(
  parameter int T_RELEASE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_tick,
  input  logic first_half,
  input  logic start_drive,
  input  logic rel_go,
  input  logic rel_wb,
  output logic retry_oe,
  output logic retry_val,
  output logic wb_go
);
  logic [T_RELEASE-1:0] go_pipe, wb_pipe;
  logic drive_q, rel_a, rel_b, go_last, release_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_pipe[0] <= 1'b0;
      wb_pipe[0] <= 1'b0;
    end else if (bus_tick) begin
      go_pipe[0] <= rel_go;
      wb_pipe[0] <= rel_wb;
    end
  end

  for (genvar gi = 1; gi < T_RELEASE; gi++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        go_pipe[gi] <= 1'b0;
        wb_pipe[gi] <= 1'b0;
      end else if (bus_tick) begin
        go_pipe[gi] <= go_pipe[gi-1];
        wb_pipe[gi] <= wb_pipe[gi-1];
      end
    end
  end

  assign go_last     = go_pipe[T_RELEASE-1];
  assign release_now = bus_tick & go_last;
  assign wb_go       = bus_tick & wb_pipe[T_RELEASE-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      rel_a   <= 1'b0;
      rel_b   <= 1'b0;
    end else if (bus_tick) begin
      if (release_now)      drive_q <= 1'b0;
      else if (start_drive) drive_q <= 1'b1;
      rel_a <= go_last;
      rel_b <= rel_a;
    end
  end

  assign retry_oe  = sar_pkg::line_oe(drive_q, rel_a, rel_b, first_half);
  assign retry_val = drive_q;

  AST_NEG_ONLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_oe && !retry_val) |-> (rel_a || rel_b)); // R4
  AST_RELB_AFTER_RELA: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tick && rel_a) |=> rel_b); // R4
  AST_DRIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q && !release_now) |=> drive_q); // R3
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_q && (rel_a || rel_b))); // R3
endmodule

// File: rtl/sar_busreq.sv
`timescale 1ns/1ps
module sar_busreq (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_tick,
  input  logic wb_go,
  input  logic bus_grant,
  output logic bus_req,
  output logic cb_start
);
  logic grant_evt;
  assign grant_evt = bus_tick & bus_grant & bus_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_req  <= 1'b0;
      cb_start <= 1'b0;
    end else begin
      cb_start <= grant_evt;
      if (wb_go)          bus_req <= 1'b1;
      else if (grant_evt) bus_req <= 1'b0;
    end
  end

  AST_BREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_tick && bus_grant)) |=> bus_req); // R6
  AST_CB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cb_start |=> !cb_start); // R7
  AST_BREQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_go |=> bus_req); // R5
endmodule

// File: rtl/snoop_retry_drv.sv
`timescale 1ns/1ps
module snoop_retry_drv #(
  parameter int T_ASSERT     = 3,
  parameter int T_SNOOP_LAST = 2,
  parameter int T_RELEASE    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_tick,
  input  logic ts_in,
  input  logic aack_in,
  input  logic snp_valid,
  input  logic snp_retry,
  input  logic snp_wb,
  input  logic bus_grant,
  output logic retry_oe,
  output logic retry_val,
  output logic bus_req,
  output logic cb_start
);
  // Named internal events, kept visible for the assertions
  logic first_half;
  logic start_drive;
  logic rel_go;
  logic rel_wb;
  logic wb_go;

  sar_phase u_phase (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .first_half(first_half)
  );

  sar_tenure #(.T_ASSERT(T_ASSERT), .T_SNOOP_LAST(T_SNOOP_LAST)) u_tenure (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
    .ts_in(ts_in), .aack_in(aack_in),
    .snp_valid(snp_valid), .snp_retry(snp_retry), .snp_wb(snp_wb),
    .start_drive(start_drive), .rel_go(rel_go), .rel_wb(rel_wb)
  );

  sar_release #(.T_RELEASE(T_RELEASE)) u_release (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .first_half(first_half),
    .start_drive(start_drive), .rel_go(rel_go), .rel_wb(rel_wb),
    .retry_oe(retry_oe), .retry_val(retry_val), .wb_go(wb_go)
  );

  sar_busreq u_busreq (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .wb_go(wb_go),
    .bus_grant(bus_grant), .bus_req(bus_req), .cb_start(cb_start)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!bus_req && !cb_start)); // R9
endmodule

// File: tb/snoop_retry_drv_tb.sv
`timescale 1ns/1ps
module snoop_retry_drv_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bus_tick, ts_in, aack_in, snp_valid, snp_retry, snp_wb, bus_grant;
  logic retry_oe, retry_val, bus_req, cb_start;

  snoop_retry_drv u_dut (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .ts_in(ts_in), .aack_in(aack_in),
    .snp_valid(snp_valid), .snp_retry(snp_retry), .snp_wb(snp_wb), .bus_grant(bus_grant),
    .retry_oe(retry_oe), .retry_val(retry_val), .bus_req(bus_req), .cb_start(cb_start)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Scenario description: up to two tenures, timestamps in bus steps
  bit en[2];
  int tt[2], aa[2], ss[2];
  bit rr[2], ww[2];
  int gg;
  string scen;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
    end
  endtask

  function automatic bit eff_retry(int i);
    // R1/R2: only a result at edge 1 or 2 after the start counts
    return en[i] && rr[i] && (ss[i] >= tt[i] + 1) && (ss[i] <= tt[i] + 2);
  endfunction

  function automatic void exp_line(int k, bit half, output bit oe, output bit val, output string req);
    oe = 0; val = 0; req = "R2";
    for (int i = 0; i < 2; i++) begin
      if (eff_retry(i)) begin
        if (k >= tt[i] + 3 && k < aa[i] + 2) begin
          oe = 1; val = 1; req = (k == tt[i] + 3) ? "R1" : "R3";
        end else if (k == aa[i] + 2) begin
          oe = half; val = 0; req = "R4";
        end else if (k == aa[i] + 3) begin
          oe = !half; val = 0; req = "R4";
        end
      end
    end
  endfunction

  function automatic bit exp_req(int k, output string req);
    bit r = 0;
    req = "R6";
    for (int i = 0; i < 2; i++)
      if (eff_retry(i) && ww[i] && k >= aa[i] + 2 && k < gg) begin
        r = 1;
        if (k == aa[i] + 2) req = "R5";
      end
    return r;
  endfunction

  task automatic clear_scen(string name);
    scen = name;
    for (int i = 0; i < 2; i++) begin
      en[i] = 0; tt[i] = 0; aa[i] = 0; ss[i] = 0; rr[i] = 0; ww[i] = 0;
    end
    gg = 1000;
  endtask

  task automatic check_half(int k, bit half);
    bit eo, ev, er;
    string rq, rrq;
    exp_line(k, half, eo, ev, rq);
    chk(retry_oe == eo, rq, int'(retry_oe), int'(eo));
    if (eo) chk(retry_val == ev, rq, int'(retry_val), int'(ev));
    er = exp_req(k, rrq);
    chk(bus_req == er, rrq, int'(bus_req), int'(er));
    chk(cb_start == (!half && k == gg && gg < 1000), "R7", int'(cb_start),
        int'(!half && k == gg && gg < 1000));
  endtask

  task automatic run(int nsteps);
    for (int k = 0; k < nsteps; k++) begin
      ts_in = 0; aack_in = 0; snp_valid = 0; snp_retry = 0; snp_wb = 0;
      for (int i = 0; i < 2; i++) if (en[i]) begin
        if (k == tt[i]) ts_in = 1;
        if (k == aa[i]) aack_in = 1;
        if (k == ss[i]) begin snp_valid = 1; snp_retry = rr[i]; snp_wb = ww[i]; end
      end
      bus_grant = (k == gg);
      bus_tick  = 1;
      @(posedge clk); @(negedge clk);
      check_half(k, 0);
      bus_tick = 0; ts_in = 0; aack_in = 0; snp_valid = 0; snp_retry = 0; snp_wb = 0;
      bus_grant = 0;
      @(posedge clk); @(negedge clk);
      check_half(k, 1);
    end
  endtask

  // R1 R3 R4: basic retry, acknowledge late
  task automatic t_basic();
    clear_scen("basic retry");
    en[0] = 1; tt[0] = 0; ss[0] = 1; rr[0] = 1; aa[0] = 5;
    run(10);
  endtask

  // R2: clean snoop, no retry
  task automatic t_clean();
    clear_scen("clean snoop");
    en[0] = 1; tt[0] = 0; ss[0] = 2; rr[0] = 0; aa[0] = 3;
    run(8);
  endtask

  // R2: retry result arriving at edge 3 is ignored
  task automatic t_late();
    clear_scen("late snoop");
    en[0] = 1; tt[0] = 0; ss[0] = 3; rr[0] = 1; ww[0] = 1; aa[0] = 4;
    run(9);
  endtask

  // R5 R6 R7: earliest acknowledge, copy-back, delayed grant
  task automatic t_copyback();
    clear_scen("copy-back");
    en[0] = 1; tt[0] = 0; ss[0] = 2; rr[0] = 1; ww[0] = 1; aa[0] = 2; gg = 7;
    run(10);
  endtask

  // R8: second retried tenure starts during the first release
  task automatic t_b2b_retry();
    clear_scen("R8 back-to-back retry");
    en[0] = 1; tt[0] = 0; ss[0] = 1; rr[0] = 1; aa[0] = 3;
    en[1] = 1; tt[1] = 4; ss[1] = 5; rr[1] = 1; ww[1] = 1; aa[1] = 6; gg = 10;
    run(13);
  endtask

  // R8: clean tenure starts during the release
  task automatic t_b2b_clean();
    clear_scen("R8 back-to-back clean");
    en[0] = 1; tt[0] = 0; ss[0] = 2; rr[0] = 1; aa[0] = 2;
    en[1] = 1; tt[1] = 3; ss[1] = 4; rr[1] = 0; aa[1] = 5;
    run(10);
  endtask

  initial begin
    rst_n = 0; bus_tick = 0; ts_in = 0; aack_in = 0; snp_valid = 0;
    snp_retry = 0; snp_wb = 0; bus_grant = 0;
    scen = "reset";
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(retry_oe == 0, "R9", int'(retry_oe), 0);
    chk(bus_req == 0,  "R9", int'(bus_req), 0);
    chk(cb_start == 0, "R9", int'(cb_start), 0);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    chk(retry_oe == 0, "R9", int'(retry_oe), 0);
    t_basic();
    t_clean();
    t_late();
    t_copyback();
    t_b2b_retry();
    t_b2b_clean();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", scen, 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule